// File: doc/BRIEF.md
# I2C Master Command Sequencer

This block sits between a command queue filled by a host and a bit-level I2C bus engine. The host pushes 11-bit command words. Each word carries one data byte and three flags: read, stop-after and restart-before. The sequencer turns each word into byte-level operations. Before the first byte, and again wherever a new address phase is needed, it adds a START and the target address in 7-bit or 10-bit form. Each operation goes to the bus engine through a request/acknowledge handshake.

The engine reports three things with each acknowledge: a not-acknowledge from the target, a loss of arbitration, or a received byte. Received bytes go into a receive FIFO. A failure raises a one-cycle abort pulse, records a one-hot cause vector and flushes both FIFOs. If the command queue runs dry while no STOP is pending, the sequencer holds the bus and flags that SCL must be kept low. The target address and addressing mode are captured only while the block is disabled.

Top module: `i2c_cmd_sequencer`

## Requirements
- R1: A command word is decoded as follows. Bits 7:0 are the write byte, bit 8 selects read, bit 9 requests a STOP after the byte, and bit 10 forces a repeated START and address before the byte. A write command produces one WRITE operation carrying bits 7:0.
- R2: Engine operation codes are START=0, WRITE=1, READ=2 and STOP=3. A request keeps its code and byte unchanged until it is acknowledged. The first command after idle is preceded by START and then a WRITE of the 7-bit address byte {target[6:0], read bit}.
- R3: In 10-bit mode the address phase is a WRITE of {5'b11110, target[9:8], 0} followed by a WRITE of target[7:0]. For a read, it continues with a repeated START and a WRITE of {5'b11110, target[9:8], 1}.
- R4: A read command ignores its data bits and issues one READ operation (byte 0). The returned byte is pushed into the receive FIFO.
- R5: A command with the stop flag is followed by a STOP operation, after which busy falls. The next command starts again with START and a full address phase.
- R6: A repeated START and address phase is inserted before a command whose restart flag is set, or whose read bit differs from the direction of the current address phase.
- R7: If the command FIFO is empty and the last byte requested no STOP, hold_scl and busy stay high and no request is made. Operation resumes with the next command, without a new START.
- R8: A READ is not requested while the receive FIFO is full. It is requested once space frees.
- R9: A not-acknowledge sets exactly one cause bit: bit 0 for a 7-bit address, bit 1 for the first 10-bit address byte (write or read form), bit 2 for the second 10-bit address byte, or bit 3 for write data. It also pulses abort, flushes both FIFOs and issues a STOP.
- R10: Arbitration loss on any operation other than STOP sets cause bit 12 and flushes both FIFOs. The sequencer returns to idle with no STOP.
- R11: A command pushed while cfg_enable is low is dropped, and cause bit 11 is set with an abort pulse.
- R12: Changes to cfg_target and cfg_ten_bit while cfg_enable is high have no effect on the address bytes sent.
- R13: A command pushed in the same cycle that an abort flushes the FIFOs is kept as the only entry and is executed afterwards.
- R14: busy is high from the first START request until the STOP (or abort to idle) completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_enable | input | 1 | Block enable; configuration captured while low |
| cfg_ten_bit | input | 1 | Select 10-bit target addressing |
| cfg_target | input | 10 | Target address |
| tx_push | input | 1 | Push a command word |
| tx_word | input | 11 | Command word |
| tx_full | output | 1 | Command FIFO full |
| tx_empty | output | 1 | Command FIFO empty |
| rx_pop | input | 1 | Pop a received byte |
| rx_data | output | 8 | Head of receive FIFO |
| rx_empty | output | 1 | Receive FIFO empty |
| eng_req | output | 1 | Operation request to bus engine |
| eng_op | output | 2 | Operation code |
| eng_wdata | output | 8 | Byte to transmit |
| eng_ack | input | 1 | Engine completed the request |
| eng_nack | input | 1 | Target did not acknowledge (with eng_ack) |
| eng_arb_lost | input | 1 | Arbitration lost (with eng_ack) |
| eng_rdata | input | 8 | Byte read (with eng_ack) |
| busy | output | 1 | Transfer in progress |
| hold_scl | output | 1 | Bus held waiting for commands |
| abort_pulse | output | 1 | One-cycle abort indication |
| abort_cause | output | 13 | One-hot cause of the last abort |

## Verification
Two functions can fall in the same cycle: the flush that follows an abort and a new command entering the queue. The bench drives a push on exactly the falling edge where its engine model returns a not-acknowledge, so that both land on one rising edge. It then expects the aborted transfer's STOP, followed by a complete new START, address and data sequence built from that single surviving word. A second overlap comes from the read-stall test. There the bench pops received bytes while the engine is still delivering new ones, so a receive push and pop share cycles, and the popped order is checked against the model queue.

// File: rtl/i2cseq_pkg.sv
package i2cseq_pkg;
  localparam int CMD_W   = 11;
  localparam int CAUSE_W = 13;
  localparam int BIT_RD  = 8;
  localparam int BIT_STP = 9;
  localparam int BIT_RS  = 10;

  localparam int CZ_A7    = 0;
  localparam int CZ_A10HI = 1;
  localparam int CZ_A10LO = 2;
  localparam int CZ_DATA  = 3;
  localparam int CZ_OFF   = 11;
  localparam int CZ_ARB   = 12;

  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2,
    OP_STOP  = 2'd3
  } eng_op_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_START, ST_AHI, ST_ALO, ST_RSTART, ST_AHR, ST_DATA, ST_NEXT, ST_STOP
  } seq_state_e;
endpackage

// File: rtl/i2cseq_fifo.sv
module i2cseq_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         flush,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr, wr_idx;
  logic [CW-1:0] count;
  logic          do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && (flush || !full);
  assign do_pop  = pop && !empty && !flush;
  assign wr_idx  = flush ? '0 : wr_ptr;
  assign rdata   = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_idx] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      rd_ptr <= '0;
      wr_ptr <= do_push ? AW'(1) : '0;
      count  <= do_push ? CW'(1) : '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + AW'(1);
      if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + AW'(1);
      count <= count + CW'(do_push) - CW'(do_pop);
    end
  end
endmodule

// File: rtl/i2cseq_addr.sv
module i2cseq_addr (
  input  logic       ten_bit,
  input  logic [9:0] target,
  input  logic       rd,
  output logic [7:0] hi_byte,
  output logic [7:0] lo_byte,
  output logic [7:0] hi_rd_byte
);
  // 10-bit header carries the two top address bits after a fixed 11110 prefix
  assign hi_byte    = ten_bit ? {5'b11110, target[9:8], 1'b0} : {target[6:0], rd};
  assign lo_byte    = target[7:0];
  assign hi_rd_byte = {5'b11110, target[9:8], 1'b1};
endmodule

// File: rtl/i2cseq_ctrl.sv
module i2cseq_ctrl
  import i2cseq_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               enable,
  input  logic               ten_bit,
  input  logic               off_push,
  input  logic [CMD_W-1:0]   head,
  input  logic               tx_empty,
  input  logic               rx_full,
  input  logic [7:0]         hi_byte,
  input  logic [7:0]         lo_byte,
  input  logic [7:0]         hi_rd_byte,
  input  logic               eng_ack,
  input  logic               eng_nack,
  input  logic               eng_arb_lost,
  output logic               eng_req,
  output logic [1:0]         eng_op,
  output logic [7:0]         eng_wdata,
  output logic               tx_pop,
  output logic               rx_push,
  output logic               flush,
  output logic               busy,
  output logic               hold_scl,
  output logic               abort_pulse,
  output logic [CAUSE_W-1:0] abort_cause
);
  seq_state_e         state, nstate;
  logic               cur_rd, rd_set;
  logic               acc, abort_now;
  logic [CAUSE_W-1:0] cause_now;
  eng_op_e            op_sel;
  logic               head_rd, head_stp, head_rs;

  assign head_rd  = head[BIT_RD];
  assign head_stp = head[BIT_STP];
  assign head_rs  = head[BIT_RS];
  assign acc      = eng_req && eng_ack;

  always_comb begin
    eng_req = 1'b0;
    op_sel  = OP_WRITE;
    eng_wdata = 8'h00;
    case (state)
      ST_START, ST_RSTART: begin eng_req = 1'b1; op_sel = OP_START; end
      ST_AHI:  begin eng_req = 1'b1; eng_wdata = hi_byte; end
      ST_ALO:  begin eng_req = 1'b1; eng_wdata = lo_byte; end
      ST_AHR:  begin eng_req = 1'b1; eng_wdata = hi_rd_byte; end
      ST_DATA: begin
        eng_req   = !(head_rd && rx_full);
        op_sel    = head_rd ? OP_READ : OP_WRITE;
        eng_wdata = head_rd ? 8'h00 : head[7:0];
      end
      ST_STOP: begin eng_req = 1'b1; op_sel = OP_STOP; end
      default: ;
    endcase
  end
  assign eng_op = op_sel;

  always_comb begin
    nstate    = state;
    tx_pop    = 1'b0;
    rx_push   = 1'b0;
    rd_set    = 1'b0;
    abort_now = 1'b0;
    cause_now = '0;
    if (acc && eng_arb_lost && state != ST_STOP) begin
      abort_now         = 1'b1;
      cause_now[CZ_ARB] = 1'b1;
      nstate            = ST_IDLE;
    end else begin
      case (state)
        ST_IDLE:   if (enable && !tx_empty) nstate = ST_START;
        ST_START:  if (acc) nstate = ST_AHI;
        ST_RSTART: if (acc) nstate = ST_AHR;
        ST_AHI: if (acc) begin
          if (eng_nack) begin
            abort_now = 1'b1;
            cause_now[ten_bit ? CZ_A10HI : CZ_A7] = 1'b1;
            nstate = ST_STOP;
          end else begin
            rd_set = 1'b1;
            nstate = ten_bit ? ST_ALO : ST_DATA;
          end
        end
        ST_ALO: if (acc) begin
          if (eng_nack) begin
            abort_now = 1'b1;
            cause_now[CZ_A10LO] = 1'b1;
            nstate = ST_STOP;
          end else begin
            nstate = head_rd ? ST_RSTART : ST_DATA;
          end
        end
        ST_AHR: if (acc) begin
          if (eng_nack) begin
            abort_now = 1'b1;
            cause_now[CZ_A10HI] = 1'b1;
            nstate = ST_STOP;
          end else begin
            nstate = ST_DATA;
          end
        end
        ST_DATA: if (acc) begin
          if (!head_rd && eng_nack) begin
            abort_now = 1'b1;
            cause_now[CZ_DATA] = 1'b1;
            nstate = ST_STOP;
          end else begin
            tx_pop  = 1'b1;
            rx_push = head_rd;
            nstate  = head_stp ? ST_STOP : ST_NEXT;
          end
        end
        ST_NEXT: if (!tx_empty) nstate = (head_rs || head_rd != cur_rd) ? ST_START : ST_DATA;
        ST_STOP: if (acc) nstate = ST_IDLE;
        default: nstate = ST_IDLE;
      endcase
    end
    if (off_push) begin
      abort_now = 1'b1;
      cause_now = '0;
      cause_now[CZ_OFF] = 1'b1;
    end
  end

  assign flush    = abort_now;
  assign busy     = (state != ST_IDLE);
  assign hold_scl = (state == ST_NEXT) && tx_empty;

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      cur_rd      <= 1'b0;
      abort_pulse <= 1'b0;
      abort_cause <= '0;
    end else begin
      state       <= nstate;
      abort_pulse <= abort_now;
      if (rd_set)    cur_rd      <= head_rd;
      if (abort_now) abort_cause <= cause_now;
    end
  end
endmodule

// File: rtl/i2c_cmd_sequencer.sv
module i2c_cmd_sequencer #(
  parameter int TX_DEPTH = 8,
  parameter int RX_DEPTH = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cfg_enable,
  input  logic        cfg_ten_bit,
  input  logic [9:0]  cfg_target,
  input  logic        tx_push,
  input  logic [10:0] tx_word,
  output logic        tx_full,
  output logic        tx_empty,
  input  logic        rx_pop,
  output logic [7:0]  rx_data,
  output logic        rx_empty,
  output logic        eng_req,
  output logic [1:0]  eng_op,
  output logic [7:0]  eng_wdata,
  input  logic        eng_ack,
  input  logic        eng_nack,
  input  logic        eng_arb_lost,
  input  logic [7:0]  eng_rdata,
  output logic        busy,
  output logic        hold_scl,
  output logic        abort_pulse,
  output logic [12:0] abort_cause
);
  import i2cseq_pkg::*;

  logic [9:0]       target_q;
  logic             ten_q;
  logic             off_push, on_push;
  logic [CMD_W-1:0] head;
  logic             tx_pop, rx_push, rx_full, flush;
  logic [7:0]       hi_byte, lo_byte, hi_rd_byte;

  always_ff @(posedge clk) begin
    if (rst) begin
      target_q <= '0;
      ten_q    <= 1'b0;
    end else if (!cfg_enable) begin
      target_q <= cfg_target;
      ten_q    <= cfg_ten_bit;
    end
  end

  assign off_push = tx_push && !cfg_enable;
  assign on_push  = tx_push && cfg_enable;

  i2cseq_fifo #(.W(CMD_W), .DEPTH(TX_DEPTH)) u_txq (
    .clk(clk), .rst(rst), .flush(flush), .push(on_push), .wdata(tx_word),
    .pop(tx_pop), .rdata(head), .empty(tx_empty), .full(tx_full)
  );

  i2cseq_fifo #(.W(8), .DEPTH(RX_DEPTH)) u_rxq (
    .clk(clk), .rst(rst), .flush(flush), .push(rx_push), .wdata(eng_rdata),
    .pop(rx_pop), .rdata(rx_data), .empty(rx_empty), .full(rx_full)
  );

  i2cseq_addr u_addr (
    .ten_bit(ten_q), .target(target_q), .rd(head[BIT_RD]),
    .hi_byte(hi_byte), .lo_byte(lo_byte), .hi_rd_byte(hi_rd_byte)
  );

  i2cseq_ctrl u_ctrl (
    .clk(clk), .rst(rst), .enable(cfg_enable), .ten_bit(ten_q), .off_push(off_push),
    .head(head), .tx_empty(tx_empty), .rx_full(rx_full),
    .hi_byte(hi_byte), .lo_byte(lo_byte), .hi_rd_byte(hi_rd_byte),
    .eng_ack(eng_ack), .eng_nack(eng_nack), .eng_arb_lost(eng_arb_lost),
    .eng_req(eng_req), .eng_op(eng_op), .eng_wdata(eng_wdata),
    .tx_pop(tx_pop), .rx_push(rx_push), .flush(flush),
    .busy(busy), .hold_scl(hold_scl),
    .abort_pulse(abort_pulse), .abort_cause(abort_cause)
  );
endmodule

// File: rtl/i2cseq_chk.sv
module i2cseq_chk (
  input logic        clk,
  input logic        rst,
  input logic        cfg_enable,
  input logic [9:0]  target_q,
  input logic        ten_q,
  input logic        tx_push,
  input logic        tx_empty,
  input logic        rx_empty,
  input logic        rx_full,
  input logic        eng_req,
  input logic [1:0]  eng_op,
  input logic [7:0]  eng_wdata,
  input logic        eng_ack,
  input logic        eng_arb_lost,
  input logic        busy,
  input logic        hold_scl,
  input logic        abort_pulse,
  input logic [12:0] abort_cause
);
  a_r2_req_held: assert property (@(posedge clk) disable iff (rst)
    eng_req && !eng_ack |=> eng_req && $stable(eng_op) && $stable(eng_wdata));

  a_r8_no_read_when_full: assert property (@(posedge clk) disable iff (rst)
    eng_req && eng_op == 2'd2 |-> !rx_full);

  a_r9_flush_both: assert property (@(posedge clk) disable iff (rst)
    abort_pulse && !$past(tx_push) |-> tx_empty && rx_empty);

  a_r9_cause_onehot: assert property (@(posedge clk) disable iff (rst)
    abort_pulse |-> $countones(abort_cause) == 1);

  a_r7_hold_quiet: assert property (@(posedge clk) disable iff (rst)
    hold_scl |-> busy && !eng_req);

  a_r5_stop_idles: assert property (@(posedge clk) disable iff (rst)
    eng_req && eng_ack && eng_op == 2'd3 |=> !busy);

  a_r10_arb_idles: assert property (@(posedge clk) disable iff (rst)
    eng_req && eng_ack && eng_arb_lost && eng_op != 2'd3 |=> !busy);

  a_r12_cfg_frozen: assert property (@(posedge clk) disable iff (rst)
    cfg_enable && $past(cfg_enable) |-> $stable(target_q) && $stable(ten_q));
endmodule

bind i2c_cmd_sequencer i2cseq_chk u_chk (
  .clk(clk), .rst(rst), .cfg_enable(cfg_enable), .target_q(target_q), .ten_q(ten_q),
  .tx_push(tx_push), .tx_empty(tx_empty), .rx_empty(rx_empty), .rx_full(rx_full),
  .eng_req(eng_req), .eng_op(eng_op), .eng_wdata(eng_wdata), .eng_ack(eng_ack),
  .eng_arb_lost(eng_arb_lost), .busy(busy), .hold_scl(hold_scl),
  .abort_pulse(abort_pulse), .abort_cause(abort_cause)
);

// File: tb/i2c_cmd_sequencer_tb.sv
`timescale 1ns/1ps
module i2c_cmd_sequencer_tb;
  localparam int TXD = 8;
  localparam int RXD = 4;
  localparam int LAT = 2;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst = 1'b1;
  logic        cfg_enable = 1'b0, cfg_ten_bit = 1'b0;
  logic [9:0]  cfg_target = 10'h05A;
  logic        tb_push = 1'b0, eng_push = 1'b0;
  logic [10:0] tb_word = '0, eng_word = '0;
  logic        tx_push;
  logic [10:0] tx_word;
  logic        tx_full, tx_empty, rx_pop = 1'b0, rx_empty;
  logic [7:0]  rx_data;
  logic        eng_req, eng_ack = 1'b0, eng_nack = 1'b0, eng_arb_lost = 1'b0;
  logic [1:0]  eng_op;
  logic [7:0]  eng_wdata, eng_rdata = '0;
  logic        busy, hold_scl, abort_pulse;
  logic [12:0] abort_cause;

  assign tx_push = tb_push | eng_push;
  assign tx_word = eng_push ? eng_word : tb_word;

  i2c_cmd_sequencer #(.TX_DEPTH(TXD), .RX_DEPTH(RXD)) u_dut (
    .clk(clk), .rst(rst), .cfg_enable(cfg_enable), .cfg_ten_bit(cfg_ten_bit),
    .cfg_target(cfg_target), .tx_push(tx_push), .tx_word(tx_word),
    .tx_full(tx_full), .tx_empty(tx_empty), .rx_pop(rx_pop), .rx_data(rx_data),
    .rx_empty(rx_empty), .eng_req(eng_req), .eng_op(eng_op), .eng_wdata(eng_wdata),
    .eng_ack(eng_ack), .eng_nack(eng_nack), .eng_arb_lost(eng_arb_lost),
    .eng_rdata(eng_rdata), .busy(busy), .hold_scl(hold_scl),
    .abort_pulse(abort_pulse), .abort_cause(abort_cause)
  );

  int n_tests = 0, n_fail = 0;
  int op_n = 0, nack_at = -1, arb_at = -1, lat = LAT, cyc = 0;
  logic [7:0] rd_val = 8'h30;
  logic       conc_arm = 1'b0;
  logic [10:0] conc_word = '0;
  logic [9:0] exp_ops[$];
  logic [7:0] exp_rx[$];

  task automatic check(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic expect_op(input int op, input int data);
    exp_ops.push_back({op[1:0], data[7:0]});
  endtask

  // Engine model: acknowledges each request after LAT idle cycles and checks it against the queue
  always @(negedge clk) begin
    logic [9:0] e;
    logic nk, ab;
    if (rst) begin
      eng_ack  <= 1'b0;
      eng_push <= 1'b0;
      lat = LAT;
    end else begin
      eng_push <= 1'b0;
      if (eng_req && eng_op == 2'd2 && exp_rx.size() >= RXD)
        check("R8 read requested with full rx", exp_rx.size(), RXD - 1);
      if (eng_ack) begin
        eng_ack <= 1'b0;
      end else if (eng_req) begin
        if (lat > 0) lat--;
        else begin
          lat = LAT;
          nk = (op_n == nack_at);
          ab = (op_n == arb_at);
          eng_ack      <= 1'b1;
          eng_nack     <= nk;
          eng_arb_lost <= ab;
          eng_rdata    <= rd_val;
          if (exp_ops.size() == 0) check("R2 unexpected engine op", {eng_op, eng_wdata}, 0);
          else begin
            e = exp_ops.pop_front();
            check("R2 engine op sequence", {eng_op, eng_wdata}, e);
          end
          check("R14 busy during operation", busy, 1);
          if (eng_op == 2'd2 && !ab) begin
            exp_rx.push_back(rd_val);
            rd_val++;
          end
          if (nk || ab) begin
            exp_rx.delete();
            if (conc_arm) begin
              eng_push <= 1'b1;
              eng_word <= conc_word;
              conc_arm = 1'b0;
            end
          end
          op_n++;
        end
      end
    end
  end

  task automatic push_cmd(input logic [10:0] w);
    @(negedge clk); tb_push = 1'b1; tb_word = w;
    @(negedge clk); tb_push = 1'b0;
  endtask

  task automatic pop_rx(input string tag);
    @(negedge clk);
    check({tag, " rx not empty"}, rx_empty, 0);
    if (exp_rx.size() == 0) check({tag, " rx model empty"}, 1, 0);
    else check({tag, " rx byte"}, rx_data, exp_rx.pop_front());
    rx_pop = 1'b1;
    @(negedge clk); rx_pop = 1'b0;
  endtask

  task automatic wait_done(input string tag);
    int t = 0;
    while ((busy || eng_req || exp_ops.size() != 0 || !tx_empty) && t < 3000) begin
      @(negedge clk); t++;
    end
    repeat (3) @(negedge clk);
    check({tag, " all expected ops seen"}, exp_ops.size(), 0);
    check({tag, " idle after"}, busy, 0);
  endtask

  task automatic start_case();
    op_n = 0; nack_at = -1; arb_at = -1;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R14 reset busy", busy, 0);
    check("R7 reset hold", hold_scl, 0);
    check("R2 reset req", eng_req, 0);
    check("R9 reset tx empty", tx_empty, 1);
    check("R4 reset rx empty", rx_empty, 1);
    check("R9 reset cause", abort_cause, 0);
    cfg_enable = 1'b1;
    @(negedge clk);

    // R1 R2 R5: plain 7-bit write, two bytes
    start_case();
    expect_op(0, 0); expect_op(1, 8'hB4); expect_op(1, 8'h11); expect_op(1, 8'h22); expect_op(3, 0);
    push_cmd(11'h011); push_cmd(11'h222);
    wait_done("R1 write");

    // R4: reads ignore data bits
    start_case();
    expect_op(0, 0); expect_op(1, 8'hB5); expect_op(2, 0); expect_op(2, 0); expect_op(3, 0);
    push_cmd(11'h155); push_cmd(11'h3AA);
    wait_done("R4 read");
    pop_rx("R4"); pop_rx("R4");
    check("R4 rx drained", rx_empty, 1);

    // R6: direction change forces a new address phase
    start_case();
    expect_op(0, 0); expect_op(1, 8'hB4); expect_op(1, 8'h33);
    expect_op(0, 0); expect_op(1, 8'hB5); expect_op(2, 0); expect_op(3, 0);
    push_cmd(11'h033); push_cmd(11'h300);
    wait_done("R6 dir change");
    pop_rx("R6");

    // R6: explicit restart flag, same direction
    start_case();
    expect_op(0, 0); expect_op(1, 8'hB4); expect_op(1, 8'h44);
    expect_op(0, 0); expect_op(1, 8'hB4); expect_op(1, 8'h55); expect_op(3, 0);
    push_cmd(11'h044); push_cmd(11'h655);
    wait_done("R6 restart flag");

    // R7: empty queue without stop holds the bus
    start_case();
    expect_op(0, 0); expect_op(1, 8'hB4); expect_op(1, 8'h66);
    push_cmd(11'h066);
    repeat (20) @(negedge clk);
    check("R7 hold_scl while starved", hold_scl, 1);
    check("R7 busy while starved", busy, 1);
    check("R7 no request while starved", eng_req, 0);
    check("R7 ops before starve", exp_ops.size(), 0);
    expect_op(1, 8'h77); expect_op(3, 0);
    push_cmd(11'h277);
    wait_done("R7 resume");
    check("R7 hold released", hold_scl, 0);

    // R8: read stall on full rx fifo, with pops overlapping pushes
    start_case();
    expect_op(0, 0); expect_op(1, 8'hB5);
    for (int i = 0; i < 6; i++) expect_op(2, 0);
    expect_op(3, 0);
    for (int i = 0; i < 5; i++) push_cmd(11'h100);
    push_cmd(11'h300);
    repeat (40) @(negedge clk);
    check("R8 stalled no request", eng_req, 0);
    check("R8 rx model full", exp_rx.size(), RXD);
    check("R8 remaining ops", exp_ops.size(), 3);
    for (int i = 0; i < 4; i++) pop_rx("R8");
    wait_done("R8 resume");
    pop_rx("R8"); pop_rx("R8");
    check("R8 rx drained", rx_empty, 1);

    // R12: target change while enabled is ignored
    start_case();
    cfg_target = 10'h011;
    expect_op(0, 0); expect_op(1, 8'hB4); expect_op(1, 8'hC1); expect_op(3, 0);
    push_cmd(11'h2C1);
    wait_done("R12 frozen target");

    // R3: 10-bit write then read
    @(negedge clk); cfg_enable = 1'b0; cfg_ten_bit = 1'b1; cfg_target = 10'h2A5;
    @(negedge clk); cfg_enable = 1'b1;
    start_case();
    expect_op(0, 0); expect_op(1, 8'hF4); expect_op(1, 8'hA5); expect_op(1, 8'h12);
    expect_op(0, 0); expect_op(1, 8'hF4); expect_op(1, 8'hA5);
    expect_op(0, 0); expect_op(1, 8'hF5); expect_op(2, 0); expect_op(3, 0);
    push_cmd(11'h012); push_cmd(11'h300);
    wait_done("R3 ten-bit");
    pop_rx("R3");

    // R9: 10-bit first header byte not acknowledged
    start_case(); nack_at = 1;
    expect_op(0, 0); expect_op(1, 8'hF4); expect_op(3, 0);
    push_cmd(11'h2AB);
    wait_done("R9 10b hi nack");
    check("R9 cause bit1", abort_cause, 13'h0002);

    // R9: 10-bit second address byte not acknowledged
    start_case(); nack_at = 2;
    expect_op(0, 0); expect_op(1, 8'hF4); expect_op(1, 8'hA5); expect_op(3, 0);
    push_cmd(11'h2AB);
    wait_done("R9 10b lo nack");
    check("R9 cause bit2", abort_cause, 13'h0004);

    @(negedge clk); cfg_enable = 1'b0; cfg_ten_bit = 1'b0; cfg_target = 10'h05A;
    @(negedge clk); cfg_enable = 1'b1;

    // R9 R13: address nack, with a push landing in the flush cycle
    start_case(); nack_at = 1; conc_arm = 1'b1; conc_word = 11'h2EE;
    expect_op(0, 0); expect_op(1, 8'hB4); expect_op(3, 0);
    expect_op(0, 0); expect_op(1, 8'hB4); expect_op(1, 8'hEE); expect_op(3, 0);
    push_cmd(11'h011); push_cmd(11'h222);
    wait_done("R13 push during flush");
    check("R9 cause bit0", abort_cause, 13'h0001);
    check("R13 queue empty at end", tx_empty, 1);

    // R9: data nack flushes the second byte
    start_case(); nack_at = 2;
    expect_op(0, 0); expect_op(1, 8'hB4); expect_op(1, 8'h88); expect_op(3, 0);
    push_cmd(11'h088); push_cmd(11'h299);
    wait_done("R9 data nack");
    check("R9 cause bit3", abort_cause, 13'h0008);

    // R10: arbitration lost, no stop
    start_case(); arb_at = 2;
    expect_op(0, 0); expect_op(1, 8'hB4); expect_op(1, 8'hAB);
    push_cmd(11'h0AB); push_cmd(11'h2CD);
    wait_done("R10 arb lost");
    check("R10 cause bit12", abort_cause, 13'h1000);

    // R11: push while disabled is dropped
    start_case();
    @(negedge clk); cfg_enable = 1'b0;
    push_cmd(11'h2FF);
    repeat (6) @(negedge clk);
    check("R11 cause bit11", abort_cause, 13'h0800);
    check("R11 command dropped", tx_empty, 1);
    check("R11 no request", eng_req, 0);
    check("R11 not busy", busy, 0);
    cfg_enable = 1'b1;
    repeat (4) @(negedge clk);
    check("R11 still no request after enable", eng_req, 0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule